// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Prescaler

This block holds an 8-bit timer/counter and an 8-bit watchdog counter. Both draw on one 8-bit prescaler that only one of them may use at a time. An owner input hands the prescaler to the timer or to the watchdog. The block that does not own it counts its own raw events one for one. A 3-bit ratio field sets the division.

The timer counts either the internal instruction clock or a selected edge of an external count pin. It can be loaded through a write strobe and raises a sticky overflow flag when it rolls over. The watchdog counts ticks from an external watchdog oscillator and gives a one-cycle timeout pulse when it wraps. A watchdog-clear command and a sleep-entry command restart it.

Which events clear the prescaler depends on its owner:
- When the timer owns it, a timer write clears it.
- When the watchdog owns it, a watchdog clear or a sleep entry clears it.
- A change of owner always clears it.

Top module: `tmr_wdt_share`

## Requirements
- R1: While `rst_n` is low at a clock edge, the timer value, the overflow flag and the timeout output return to 0.
- R2: With `pre_to_wdt`=0 and the internal source, the timer advances once per 2^(`ratio`+1) clock cycles, counted from the prescaler clear. With `ratio` 0 this is divide-by-2; with `ratio` 7 it is divide-by-256.
- R3: With `pre_to_wdt`=1, the timer counts its source without prescaling. With the internal source it advances once every clock cycle.
- R4: With `src_ext`=1, the timer counts only the selected edge of `ext_pin`: rising edges when `ext_fall`=0, falling edges when `ext_fall`=1. The pin passes two synchronizer flops and an edge register, so the count changes at the third rising clock edge after the pin changes. The internal clock is then ignored.
- R5: `tmr_wr` loads `tmr_wdata` at the next edge. It clears the prescaler only when `pre_to_wdt`=0.
- R6: A timer increment from 0xFF to 0x00 sets `ovf_flag`. The flag stays set until `ovf_clr` is high at an edge. When a rollover and `ovf_clr` fall in the same cycle, the flag is set.
- R7: With `pre_to_wdt`=0, the watchdog advances once per `wdt_tick` cycle. On the 256th tick after a clear, `wdt_timeout` goes high for exactly the one following cycle.
- R8: With `pre_to_wdt`=1, the watchdog advances once per 2^`ratio` ticks. The timeout comes on tick 256·2^`ratio` after a clear.
- R9: `wdt_clr` or `sleep_enter` clears the watchdog counter. When `pre_to_wdt`=1, it also clears the prescaler.
- R10: Any change of `pre_to_wdt` clears the prescaler.
- R11: A timer write takes priority over a same-cycle increment. No rollover and no flag come from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one instruction clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Value loaded into the timer |
| wdt_clr | input | 1 | Watchdog clear command |
| sleep_enter | input | 1 | Sleep entry command; clears the watchdog |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| pre_to_wdt | input | 1 | Prescaler owner: 0 timer, 1 watchdog |
| ratio | input | 3 | Prescaler ratio select |
| src_ext | input | 1 | Timer source: 0 internal clock, 1 external pin |
| ext_fall | input | 1 | External edge: 0 rising, 1 falling |
| ext_pin | input | 1 | Asynchronous external count input |
| wdt_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| tmr_value | output | 8 | Current timer value |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The bench builds the block with its default parameters: 8-bit prescaler, timer and watchdog, a 3-bit ratio and a two-stage synchronizer. These widths keep a full watchdog period under a few thousand ticks. The bench can therefore observe timeouts at ratios 0, 1 and 2 and show whether the prescaler was cleared: a stale count moves the timeout one tick earlier. The timer ratios span divide-by-2 to divide-by-256 within a few hundred cycles.

// File: rtl/tmrw_pkg.sv
// Shared types and default widths for the shared-prescaler timer/watchdog.
// Assumes: the ratio field never asks for more division than the prescaler width gives.
package tmrw_pkg;

    localparam int TMR_W_DEF  = 8;
    localparam int WDT_W_DEF  = 8;
    localparam int PRE_W_DEF  = 8;
    localparam int SEL_W_DEF  = 3;
    localparam int SYNC_N_DEF = 2;

    // Which counter the prescaler serves.
    typedef enum logic {
        OWN_TMR = 1'b0,
        OWN_WDT = 1'b1
    } pre_owner_e;

endpackage

// File: rtl/tmrw_edge_sync.sv
// Synchronizes an asynchronous pin through SYNC_N flops and emits a one-cycle
// pulse on the selected edge. Assumes SYNC_N >= 2 and pin pulses wider than
// two clock cycles.
module tmrw_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sel_fall,
    output logic edge_pulse
);

    logic [SYNC_N-1:0] stage;
    logic              prev_q;
    logic              synced;

    assign synced = stage[SYNC_N-1];

    // Input flop of the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage[0] <= 1'b0;
        end else begin
            stage[0] <= pin;
        end
    end

    // Remaining synchronizer stages, one per generate iteration.
    for (genvar g = 1; g < SYNC_N; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage[g] <= 1'b0;
            end else begin
                stage[g] <= stage[g-1];
            end
        end
    end

    // Remember the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= synced;
        end
    end

    // Pick the rising or the falling transition.
    always_comb begin
        if (sel_fall) begin
            edge_pulse = !synced && prev_q;
        end else begin
            edge_pulse = synced && !prev_q;
        end
    end

endmodule

// File: rtl/tmrw_prescaler.sv
// Shared prescaler: a free-running up-counter of input events with a tap that
// fires once every 2^k events. k is ratio+1 for the timer owner and ratio for the
// watchdog owner. A clear wins over counting and suppresses the tap in that cycle.
// Assumes: ratio+1 <= PRE_W.
module tmrw_prescaler #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    input  logic             to_wdt,
    input  logic [SEL_W-1:0] ratio,
    output logic             tap,
    output logic [PRE_W-1:0] count
);

    localparam int SPAN_W = PRE_W + 1;

    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] span_m1;
    logic [PRE_W-1:0]  mask;

    // Division span as a power of two, chosen by owner.
    always_comb begin
        if (to_wdt) begin
            span = SPAN_W'(1) << ratio;
        end else begin
            span = SPAN_W'(1) << (int'(ratio) + 1);
        end
        span_m1 = span - SPAN_W'(1);
        mask    = span_m1[PRE_W-1:0];
    end

    // Tap fires on the event that completes a full span.
    assign tap = evt && !clr && ((count & mask) == mask);

    // Event counter with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (evt) begin
            count <= count + PRE_W'(1);
        end
    end

endmodule

// File: rtl/tmrw_wrap_ctr.sv
// Up-counter with synchronous clear, parallel load and increment, in that
// priority order. Flags a wrap from all ones to zero caused by an increment.
module tmrw_wrap_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);

    // Wrap only when the increment actually takes effect.
    assign wrap = inc && !clr && !load && (&value);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (load) begin
            value <= ld_val;
        end else if (inc) begin
            value <= value + W'(1);
        end
    end

endmodule

// File: rtl/tmr_wdt_share.sv
// Timer/counter and watchdog that share one prescaler. pre_to_wdt picks the
// owner. The owner counts prescaled events; the other block counts raw events.
// Assumes wdt_tick is already synchronous to clk and at most one cycle per tick.
module tmr_wdt_share #(
    parameter int TMR_W  = tmrw_pkg::TMR_W_DEF,
    parameter int WDT_W  = tmrw_pkg::WDT_W_DEF,
    parameter int PRE_W  = tmrw_pkg::PRE_W_DEF,
    parameter int SEL_W  = tmrw_pkg::SEL_W_DEF,
    parameter int SYNC_N = tmrw_pkg::SYNC_N_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_wr,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             wdt_clr,
    input  logic             sleep_enter,
    input  logic             ovf_clr,
    input  logic             pre_to_wdt,
    input  logic [SEL_W-1:0] ratio,
    input  logic             src_ext,
    input  logic             ext_fall,
    input  logic             ext_pin,
    input  logic             wdt_tick,
    output logic [TMR_W-1:0] tmr_value,
    output logic             ovf_flag,
    output logic             wdt_timeout
);

    import tmrw_pkg::*;

    pre_owner_e       owner;
    logic             owner_q;
    logic             owner_chg;
    logic             ext_edge;
    logic             tmr_raw;
    logic             pre_evt;
    logic             pre_clr;
    logic             pre_tap;
    logic [PRE_W-1:0] pre_count;
    logic             tmr_inc;
    logic             tmr_wrap;
    logic             wdt_inc;
    logic             wdt_restart;
    logic             wdt_wrap;
    logic [WDT_W-1:0] wdt_count;

    assign owner = pre_owner_e'(pre_to_wdt);

    // Previous owner, tracked also in reset so a change is never missed.
    always_ff @(posedge clk) begin
        owner_q <= pre_to_wdt;
    end

    assign owner_chg = (pre_to_wdt != owner_q);

    tmrw_edge_sync #(
        .SYNC_N (SYNC_N)
    ) i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (ext_pin),
        .sel_fall   (ext_fall),
        .edge_pulse (ext_edge)
    );

    // Raw timer event: one per instruction clock or one per selected pin edge.
    assign tmr_raw     = src_ext ? ext_edge : 1'b1;
    assign wdt_restart = wdt_clr || sleep_enter;

    // Route events and clear causes to and from the prescaler by owner.
    always_comb begin
        if (owner == OWN_WDT) begin
            pre_evt = wdt_tick;
            pre_clr = owner_chg || wdt_restart;
            tmr_inc = tmr_raw;
            wdt_inc = pre_tap;
        end else begin
            pre_evt = tmr_raw;
            pre_clr = owner_chg || tmr_wr;
            tmr_inc = pre_tap;
            wdt_inc = wdt_tick;
        end
    end

    tmrw_prescaler #(
        .PRE_W (PRE_W),
        .SEL_W (SEL_W)
    ) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pre_clr),
        .evt    (pre_evt),
        .to_wdt (pre_to_wdt),
        .ratio  (ratio),
        .tap    (pre_tap),
        .count  (pre_count)
    );

    tmrw_wrap_ctr #(
        .W (TMR_W)
    ) i_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (1'b0),
        .load   (tmr_wr),
        .ld_val (tmr_wdata),
        .inc    (tmr_inc),
        .value  (tmr_value),
        .wrap   (tmr_wrap)
    );

    tmrw_wrap_ctr #(
        .W (WDT_W)
    ) i_wdt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wdt_restart),
        .load   (1'b0),
        .ld_val ('0),
        .inc    (wdt_inc),
        .value  (wdt_count),
        .wrap   (wdt_wrap)
    );

    // Sticky overflow flag; a rollover wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (tmr_wrap) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end
    end

    // One-cycle timeout pulse registered from the watchdog wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_timeout <= 1'b0;
        end else begin
            wdt_timeout <= wdt_wrap;
        end
    end

endmodule

// Checker for tmr_wdt_share: port behaviour and prescaler clear rules.
module tmrw_chk #(
    parameter int TMR_W = 8,
    parameter int WDT_W = 8,
    parameter int PRE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_wr,
    input logic [TMR_W-1:0] tmr_wdata,
    input logic             wdt_clr,
    input logic             sleep_enter,
    input logic             ovf_clr,
    input logic             pre_to_wdt,
    input logic [TMR_W-1:0] tmr_value,
    input logic             ovf_flag,
    input logic             wdt_timeout,
    input logic [PRE_W-1:0] pre_count,
    input logic [WDT_W-1:0] wdt_count
);

    // R6
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(tmr_value) == {TMR_W{1'b1}} && !$past(tmr_wr)));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R7
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !wdt_timeout);

    // R5
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> (tmr_value == $past(tmr_wdata)));

    // R2
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_wr |=> (tmr_value == $past(tmr_value) ||
                     tmr_value == TMR_W'($past(tmr_value) + TMR_W'(1))));

    // R9
    wdt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr || sleep_enter) |=> (wdt_count == '0 && !wdt_timeout));

    // R9
    wdt_pre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_to_wdt && (wdt_clr || sleep_enter)) |=> (pre_count == '0));

    // R10
    owner_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_to_wdt != $past(pre_to_wdt)) |=> (pre_count == '0));

endmodule

bind tmr_wdt_share tmrw_chk #(
    .TMR_W (TMR_W),
    .WDT_W (WDT_W),
    .PRE_W (PRE_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_wr      (tmr_wr),
    .tmr_wdata   (tmr_wdata),
    .wdt_clr     (wdt_clr),
    .sleep_enter (sleep_enter),
    .ovf_clr     (ovf_clr),
    .pre_to_wdt  (pre_to_wdt),
    .tmr_value   (tmr_value),
    .ovf_flag    (ovf_flag),
    .wdt_timeout (wdt_timeout),
    .pre_count   (pre_count),
    .wdt_count   (wdt_count)
);

// File: tb/test_tmr_wdt_share.sv
// Directed bench: one task per scenario; inputs change on falling edges.
module test_tmr_wdt_share;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_wr = 1'b0;
    logic [7:0] tmr_wdata = 8'h00;
    logic       wdt_clr = 1'b0;
    logic       sleep_enter = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       pre_to_wdt = 1'b0;
    logic [2:0] ratio = 3'd0;
    logic       src_ext = 1'b0;
    logic       ext_fall = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wdt_tick = 1'b0;
    logic [7:0] tmr_value;
    logic       ovf_flag;
    logic       wdt_timeout;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tmr_wdt_share i_tmr_wdt_share (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_wr      (tmr_wr),
        .tmr_wdata   (tmr_wdata),
        .wdt_clr     (wdt_clr),
        .sleep_enter (sleep_enter),
        .ovf_clr     (ovf_clr),
        .pre_to_wdt  (pre_to_wdt),
        .ratio       (ratio),
        .src_ext     (src_ext),
        .ext_fall    (ext_fall),
        .ext_pin     (ext_pin),
        .wdt_tick    (wdt_tick),
        .tmr_value   (tmr_value),
        .ovf_flag    (ovf_flag),
        .wdt_timeout (wdt_timeout)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic write_tmr(input logic [7:0] v);
        tmr_wr = 1'b1;
        tmr_wdata = v;
        @(negedge clk);
        tmr_wr = 1'b0;
    endtask

    task automatic pulse_wdt_clr();
        wdt_clr = 1'b1;
        @(negedge clk);
        wdt_clr = 1'b0;
    endtask

    task automatic pulse_ovf_clr();
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
    endtask

    task automatic run_ticks(input int n, output int first, output int cnt);
        first = 0;
        cnt = 0;
        wdt_tick = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (wdt_timeout) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
        wdt_tick = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 tmr_value", tmr_value, 0);
        check("R1 ovf_flag", ovf_flag, 0);
        check("R1 wdt_timeout", wdt_timeout, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_div(input int r, input int n);
        pre_to_wdt = 1'b0;
        src_ext = 1'b0;
        ratio = 3'(r);
        @(negedge clk);
        write_tmr(8'h00);
        repeat (n) @(negedge clk);
        check($sformatf("R2 ratio %0d after %0d cycles", r, n), tmr_value, n >> (r + 1));
    endtask

    task automatic t_raw_timer();
        pre_to_wdt = 1'b1;
        src_ext = 1'b0;
        ratio = 3'd7;
        @(negedge clk);
        write_tmr(8'd10);
        repeat (20) @(negedge clk);
        check("R3 unprescaled timer", tmr_value, 30);
    endtask

    task automatic t_ext();
        pre_to_wdt = 1'b1;
        src_ext = 1'b1;
        ext_fall = 1'b0;
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        write_tmr(8'h00);
        repeat (6) @(negedge clk);
        check("R4 steady pin, clock ignored", tmr_value, 0);
        ext_pin = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 two edges after rise", tmr_value, 0);
        @(negedge clk);
        check("R4 counted at third edge", tmr_value, 1);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 falling ignored in rise mode", tmr_value, 1);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 second rise", tmr_value, 2);
        ext_fall = 1'b1;
        repeat (2) @(negedge clk);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 fall counted in fall mode", tmr_value, 3);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 rise ignored in fall mode", tmr_value, 3);
        src_ext = 1'b0;
        ext_fall = 1'b0;
    endtask

    task automatic t_overflow();
        pre_to_wdt = 1'b1;
        src_ext = 1'b0;
        pulse_ovf_clr();
        write_tmr(8'hFE);
        @(negedge clk);
        check("R6 at 0xFF no flag", ovf_flag, 0);
        @(negedge clk);
        check("R6 rollover value", tmr_value, 0);
        check("R6 rollover sets flag", ovf_flag, 1);
        repeat (3) @(negedge clk);
        check("R6 flag sticky", ovf_flag, 1);
        pulse_ovf_clr();
        check("R6 flag cleared", ovf_flag, 0);
        write_tmr(8'hFE);
        @(negedge clk);
        pulse_ovf_clr();
        check("R6 set wins over clear", ovf_flag, 1);
        pulse_ovf_clr();
        write_tmr(8'hFF);
        write_tmr(8'h40);
        check("R11 write wins over count", tmr_value, 8'h40);
        check("R11 no flag from overwritten wrap", ovf_flag, 0);
    endtask

    task automatic t_owner_change();
        pre_to_wdt = 1'b0;
        src_ext = 1'b0;
        ratio = 3'd2;
        @(negedge clk);
        write_tmr(8'h00);
        repeat (5) @(negedge clk);
        check("R2 div8 before switch", tmr_value, 0);
        pre_to_wdt = 1'b1;
        @(negedge clk);
        check("R3 raw count while watchdog owns", tmr_value, 1);
        pre_to_wdt = 1'b0;
        @(negedge clk);
        check("R10 no count on switch back", tmr_value, 1);
        repeat (7) @(negedge clk);
        check("R10 prescaler restarted", tmr_value, 1);
        @(negedge clk);
        check("R10 full span after switch", tmr_value, 2);
    endtask

    task automatic t_wdt_raw();
        int first;
        int cnt;
        pre_to_wdt = 1'b0;
        @(negedge clk);
        pulse_wdt_clr();
        run_ticks(300, first, cnt);
        check("R7 timeout on tick 256", first, 256);
        check("R7 single pulse", cnt, 1);
    endtask

    task automatic t_wdt_pre();
        int first;
        int cnt;
        pre_to_wdt = 1'b1;
        ratio = 3'd2;
        @(negedge clk);
        pulse_wdt_clr();
        run_ticks(1100, first, cnt);
        check("R8 ratio 2 timeout on tick 1024", first, 1024);
        check("R8 single pulse", cnt, 1);
        ratio = 3'd1;
        pulse_wdt_clr();
        run_ticks(1, first, cnt);
        pulse_wdt_clr();
        run_ticks(600, first, cnt);
        check("R9 clear also restarts prescaler", first, 512);
        pulse_wdt_clr();
        run_ticks(1, first, cnt);
        write_tmr(8'h00);
        run_ticks(600, first, cnt);
        check("R5 write leaves watchdog prescaler", first, 511);
    endtask

    task automatic t_sleep();
        int first;
        int cnt;
        pre_to_wdt = 1'b0;
        @(negedge clk);
        pulse_wdt_clr();
        run_ticks(200, first, cnt);
        sleep_enter = 1'b1;
        @(negedge clk);
        sleep_enter = 1'b0;
        run_ticks(255, first, cnt);
        check("R9 sleep restarts watchdog", cnt, 0);
        run_ticks(1, first, cnt);
        check("R9 timeout after 256 post-sleep ticks", cnt, 1);
        @(negedge clk);
        check("R7 pulse lasts one cycle", wdt_timeout, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        @(negedge clk);
        t_div(0, 10);
        t_div(3, 40);
        t_div(7, 600);
        t_raw_timer();
        t_ext();
        t_overflow();
        t_owner_change();
        t_wdt_raw();
        t_wdt_pre();
        t_sleep();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule